// File: doc/BRIEF.md
# Crystal Frequency Window Monitor

This block watches two crystal clocks from a reference clock domain. The high-speed crystal is checked in two ways. Its rising edges are counted over a fixed window of reference cycles, and the count is compared against programmable 11-bit lower and upper limits. Separately, a stop detector declares it dead when no rising edge arrives for a set number of reference cycles. The low-speed crystal has only a stop detector. Each crystal input is brought into the reference domain by a two-flop synchronizer followed by a rising-edge detector. This means a monitored clock must toggle at less than half the reference rate to be counted accurately.

Every detector has its own enable bit. Each condition latches into a sticky flag, and software clears a flag by writing 1 to its bit. Each flag also has its own interrupt enable, and the single interrupt output is the OR of all enabled flags. Software uses the block by first programming the limits, then setting the enables, and then reacting to the interrupt or polling the flag register.

Top module: `xtal_freq_monitor`

## Requirements
- R1: After reset every register reads 0 and `irq_o` is 0.
- R2: Register addresses: 0 = detector enables, 1 = interrupt enables, 2 = flags, 3 = upper limit, 4 = lower limit. Enable, interrupt-enable and flag registers use bit 0 for high-speed stop, bit 1 for low-speed stop and bit 2 for high-speed frequency. Those registers keep only bits [2:0], and the unused bits read as 0. The limit registers keep all 11 bits. Any other address reads 0.
- R3: Crystal inputs pass through a `SYNC_STAGES`-flop synchronizer and a rising-edge detector. Each rising edge is counted once.
- R4: While the frequency check is enabled, it counts high-speed rising edges over consecutive windows of `WIN_LEN` reference cycles. Counting starts afresh when the check is enabled. At the end of a window, a count strictly above the upper limit sets flag bit 2.
- R5: At the end of a window, a count strictly below the lower limit also sets flag bit 2. A count equal to either limit does not set it.
- R6: The edge count saturates at 2047 (all ones of `CNT_W`) and does not wrap within a window.
- R7: A stop flag (bit 0 high-speed, bit 1 low-speed) is set once its enabled detector has seen `STOP_LIM` (32) consecutive reference cycles with no rising edge. A gap of fewer cycles never sets it.
- R8: A detector whose enable is 0 never sets its flag, and its counters are held at zero.
- R9: Flags are sticky. Writing 1 to a flag bit clears that bit only, and writing 0 leaves it unchanged. When a set condition and a clear occur in the same cycle, the set wins.
- R10: `irq_o` is 1 exactly when some flag bit and its interrupt-enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_xtal_i | input | 1 | High-speed crystal, sampled as data |
| ls_xtal_i | input | 1 | Low-speed crystal, sampled as data |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | CNT_W (11) | Write data |
| cfg_rdata | output | CNT_W (11) | Read data for `cfg_addr`, combinational |
| irq_o | output | 1 | Interrupt, OR of enabled flags |

## Verification
The hardest case to reach from the ports is saturation of the edge count. A plain window of 1024 cycles can never hold more than 512 edges, so the bench builds the monitor with a 4096-cycle window and toggles the crystal every reference cycle. This produces 2048 edges, and the bench sets the upper limit to 2047: a wrapping or unsaturated counter would trip the flag, while a correct one does not. The stop detector's threshold is bracketed the same way, with crystal gaps of 30 and 40 reference cycles. The set-beats-clear rule is reached by clearing the low-speed stop flag while that crystal is still held stopped.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
  localparam int unsigned NUM_FLAGS   = 3;
  localparam int unsigned FLG_HS_STOP = 0;
  localparam int unsigned FLG_LS_STOP = 1;
  localparam int unsigned FLG_HS_FREQ = 2;

  localparam logic [2:0] ADR_ENABLE = 3'd0;
  localparam logic [2:0] ADR_IRQ_EN = 3'd1;
  localparam logic [2:0] ADR_FLAGS  = 3'd2;
  localparam logic [2:0] ADR_UPPER  = 3'd3;
  localparam logic [2:0] ADR_LOWER  = 3'd4;

  typedef logic [NUM_FLAGS-1:0] flag_vec_t;
endpackage

// File: rtl/xmon_edge_sync.sv
module xmon_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[SYNC_STAGES-1:0], din};
  end

  assign rise = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];

  AST_EDGE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R3
endmodule

// File: rtl/xmon_stop_det.sv
module xmon_stop_det #(
  parameter int unsigned STOP_LIM = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rise,
  output logic stopped
);
  localparam int unsigned CW = $clog2(STOP_LIM + 1);
  localparam logic [CW-1:0] LIM = CW'(STOP_LIM);

  logic [CW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          gap_q <= '0;
    else if (!en)        gap_q <= '0;
    else if (rise)       gap_q <= '0;
    else if (gap_q != LIM) gap_q <= gap_q + CW'(1);
  end

  assign stopped = en && (gap_q == LIM);

  AST_EDGE_CLEARS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !stopped); // R7
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (gap_q == '0) || en); // R8
endmodule

// File: rtl/xmon_freq_win.sv
module xmon_freq_win #(
  parameter int unsigned WIN_LEN = 1024,
  parameter int unsigned CNT_W   = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             rise,
  input  logic [CNT_W-1:0] upper,
  input  logic [CNT_W-1:0] lower,
  output logic             fail
);
  localparam int unsigned WW = $clog2(WIN_LEN);
  localparam logic [WW-1:0]    WIN_LAST = WW'(WIN_LEN - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [WW-1:0]    win_q;
  logic [CNT_W-1:0] edge_q;
  logic [CNT_W-1:0] meas;
  logic             win_end;
  logic             out_of_range;

  assign win_end      = (win_q == WIN_LAST);
  assign meas         = (rise && edge_q != CNT_MAX) ? edge_q + CNT_W'(1) : edge_q;
  assign out_of_range = (meas > upper) || (meas < lower);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      edge_q <= '0;
      fail   <= 1'b0;
    end else if (!en) begin
      win_q  <= '0;
      edge_q <= '0;
      fail   <= 1'b0;
    end else begin
      fail <= win_end && out_of_range;
      if (win_end) begin
        win_q  <= '0;
        edge_q <= '0;
      end else begin
        win_q  <= win_q + WW'(1);
        edge_q <= meas;
      end
    end
  end

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && edge_q == CNT_MAX && !win_end) |=> (!en || edge_q == CNT_MAX)); // R6
  AST_FAIL_ONCE_PER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail); // R4
endmodule

// File: rtl/xmon_regs.sv
module xmon_regs
  import xmon_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0] cfg_rdata,
  input  flag_vec_t        set_i,
  output flag_vec_t        en_o,
  output logic [CNT_W-1:0] upper_o,
  output logic [CNT_W-1:0] lower_o,
  output logic             irq_o
);
  flag_vec_t        en_q, ie_q, flags_q, clr;
  logic [CNT_W-1:0] up_q, lo_q;

  assign clr = (cfg_we && cfg_addr == ADR_FLAGS) ? cfg_wdata[NUM_FLAGS-1:0] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      ie_q    <= '0;
      flags_q <= '0;
      up_q    <= '0;
      lo_q    <= '0;
    end else begin
      flags_q <= (flags_q & ~clr) | set_i;
      if (cfg_we) begin
        case (cfg_addr)
          ADR_ENABLE: en_q <= cfg_wdata[NUM_FLAGS-1:0];
          ADR_IRQ_EN: ie_q <= cfg_wdata[NUM_FLAGS-1:0];
          ADR_UPPER:  up_q <= cfg_wdata;
          ADR_LOWER:  lo_q <= cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      ADR_ENABLE: cfg_rdata = CNT_W'(en_q);
      ADR_IRQ_EN: cfg_rdata = CNT_W'(ie_q);
      ADR_FLAGS:  cfg_rdata = CNT_W'(flags_q);
      ADR_UPPER:  cfg_rdata = up_q;
      ADR_LOWER:  cfg_rdata = lo_q;
      default:    cfg_rdata = '0;
    endcase
  end

  assign en_o    = en_q;
  assign upper_o = up_q;
  assign lower_o = lo_q;
  assign irq_o   = |(flags_q & ie_q);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_we && cfg_addr == ADR_FLAGS) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R9
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == ADR_FLAGS && |(cfg_wdata[NUM_FLAGS-1:0] & ~set_i))
      |=> ((flags_q & $past(cfg_wdata[NUM_FLAGS-1:0] & ~set_i)) == '0)); // R9
endmodule

// File: rtl/xtal_freq_monitor.sv
module xtal_freq_monitor
  import xmon_pkg::*;
#(
  parameter int unsigned WIN_LEN     = 1024,
  parameter int unsigned CNT_W       = 11,
  parameter int unsigned STOP_LIM    = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_xtal_i,
  input  logic             ls_xtal_i,
  input  logic             cfg_we,
  input  logic [2:0]       cfg_addr,
  input  logic [CNT_W-1:0] cfg_wdata,
  output logic [CNT_W-1:0] cfg_rdata,
  output logic             irq_o
);
  localparam int unsigned NUM_XTAL = 2;

  logic [NUM_XTAL-1:0] xtal_in, rise, stopped, stop_en;
  flag_vec_t           en, set_vec;
  logic [CNT_W-1:0]    upper, lower;
  logic                freq_fail;

  assign xtal_in = {ls_xtal_i, hs_xtal_i};
  assign stop_en = {en[FLG_LS_STOP], en[FLG_HS_STOP]};

  for (genvar c = 0; c < NUM_XTAL; c++) begin : g_xtal
    xmon_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (xtal_in[c]),
      .rise  (rise[c])
    );
    xmon_stop_det #(.STOP_LIM(STOP_LIM)) u_stop (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (stop_en[c]),
      .rise    (rise[c]),
      .stopped (stopped[c])
    );
  end

  xmon_freq_win #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en[FLG_HS_FREQ]),
    .rise  (rise[0]),
    .upper (upper),
    .lower (lower),
    .fail  (freq_fail)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[FLG_HS_STOP] = stopped[0];
    set_vec[FLG_LS_STOP] = stopped[1];
    set_vec[FLG_HS_FREQ] = freq_fail;
  end

  xmon_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .set_i     (set_vec),
    .en_o      (en),
    .upper_o   (upper),
    .lower_o   (lower),
    .irq_o     (irq_o)
  );
endmodule

// File: tb/xtal_freq_monitor_tb.sv
module xtal_freq_monitor_tb;
  localparam int unsigned WIN = 4096;
  localparam int unsigned CW  = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_xtal = 1'b0, ls_xtal = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [CW-1:0] cfg_rdata;
  logic irq;
  int hs_half = 0, ls_half = 0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  xtal_freq_monitor #(.WIN_LEN(WIN)) u_dut (
    .clk(clk), .rst_n(rst_n), .hs_xtal_i(hs_xtal), .ls_xtal_i(ls_xtal),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .irq_o(irq)
  );

  initial forever begin
    if (hs_half == 0) begin hs_xtal <= 1'b0; @(negedge clk); end
    else begin repeat (hs_half) @(negedge clk); hs_xtal <= ~hs_xtal; end
  end
  initial forever begin
    if (ls_half == 0) begin ls_xtal <= 1'b0; @(negedge clk); end
    else begin repeat (ls_half) @(negedge clk); ls_xtal <= ~ls_xtal; end
  end

  typedef struct packed {
    logic [7:0]    half;
    logic [CW-1:0] up;
    logic [CW-1:0] lo;
    logic          fail;
  } vec_t;

  // half-period in reference cycles, upper, lower, expected frequency flag
  localparam vec_t VECS [9] = '{
    '{8'd2,  11'd1100, 11'd900,  1'b0},   // R4 in range (~1024)
    '{8'd2,  11'd1000, 11'd900,  1'b1},   // R4 above upper
    '{8'd4,  11'd1100, 11'd600,  1'b1},   // R5 below lower (~512)
    '{8'd4,  11'd600,  11'd400,  1'b0},   // R3 counted once per edge
    '{8'd1,  11'd2047, 11'd1500, 1'b0},   // R6 2048 edges saturate at 2047
    '{8'd16, 11'd140,  11'd120,  1'b0},   // R4 (~128)
    '{8'd16, 11'd100,  11'd50,   1'b1},   // R4 above upper
    '{8'd0,  11'd100,  11'd1,    1'b1},   // R5 stopped, 0 < 1
    '{8'd0,  11'd0,    11'd0,    1'b0}    // R5 equal to both limits
  };

  task automatic check(input string req, input logic [CW-1:0] act, input logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [CW-1:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [CW-1:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); check("R1 reset register", v, '0);
    end
    check("R1 reset irq", CW'(irq), '0);

    // R2 register widths and map
    wr(3'd3, 11'h7FF); rd(3'd3, v); check("R2 upper 11-bit", v, 11'h7FF);
    wr(3'd0, 11'h7F8); rd(3'd0, v); check("R2 enable keeps [2:0]", v, 11'h000);
    wr(3'd1, 11'h7FF); rd(3'd1, v); check("R2 irq enable keeps [2:0]", v, 11'h007);
    rd(3'd6, v); check("R2 unmapped reads 0", v, '0);
    wr(3'd1, 11'h000);

    // table-driven frequency window checks
    for (int i = 0; i < 9; i++) begin
      wr(3'd0, 11'h000);
      hs_half = int'(VECS[i].half);
      wr(3'd3, VECS[i].up);
      wr(3'd4, VECS[i].lo);
      wr(3'd2, 11'h007);
      repeat (20) @(negedge clk);
      wr(3'd0, 11'h004);
      repeat (WIN + 20) @(negedge clk);
      rd(3'd2, v);
      // stop detectors disabled: bits 0/1 must stay 0 (R8)
      check($sformatf("R4/R5 window row %0d", i), v, {8'd0, VECS[i].fail, 2'b00});
    end
    wr(3'd0, 11'h000);
    hs_half = 0;
    wr(3'd2, 11'h007);

    // R7 stop detector on low-speed crystal
    ls_half = 4;
    wr(3'd0, 11'h002);
    repeat (300) @(negedge clk);
    rd(3'd2, v); check("R7 running clock no stop", v, 11'h000);
    ls_half = 15;
    repeat (300) @(negedge clk);
    rd(3'd2, v); check("R7 30-cycle gap no stop", v, 11'h000);
    ls_half = 20;
    repeat (300) @(negedge clk);
    rd(3'd2, v); check("R7 40-cycle gap stops", v, 11'h002);
    check("R10 irq masked", CW'(irq), '0);
    wr(3'd1, 11'h002);
    #1 check("R10 irq enabled flag", CW'(irq), 11'h001);
    wr(3'd1, 11'h005);
    #1 check("R10 irq other enables", CW'(irq), '0);

    // R9 write-1-clear behaviour
    ls_half = 0;
    wr(3'd0, 11'h003);
    repeat (100) @(negedge clk);
    rd(3'd2, v); check("R7 both stopped", v, 11'h003);
    wr(3'd2, 11'h002);
    rd(3'd2, v); check("R9 set wins over clear", v, 11'h003);
    wr(3'd0, 11'h000);
    wr(3'd2, 11'h000);
    rd(3'd2, v); check("R9 write 0 no effect", v, 11'h003);
    wr(3'd2, 11'h002);
    rd(3'd2, v); check("R9 selective clear", v, 11'h001);
    #1 check("R10 irq from bit0", CW'(irq), 11'h001);
    wr(3'd2, 11'h001);
    rd(3'd2, v); check("R9 clear last flag", v, 11'h000);
    check("R10 irq drops", CW'(irq), '0);

    // R8 disabled detectors stay quiet with stopped clocks
    repeat (200) @(negedge clk);
    rd(3'd2, v); check("R8 disabled no flags", v, 11'h000);

    done = 1'b1;
    finish_run();
  end
endmodule